// File: doc/BRIEF.md
# Dual-Pipe Issue Pairing Stage

This block is the in-order issue stage of a streaming vector core. Each cycle it looks at the two oldest instructions in a two-entry window. Each instruction arrives already tagged with a unit class, a destination register and two source registers. The stage sends zero, one or two of them to an even (arithmetic) pipe and an odd (permute, memory, channel and branch) pipe. There is no reordering, speculation, renaming or prediction, so the younger entry can only go when the older one goes in the same cycle.

Two instructions go together only when their classes need different pipes and the younger does not read what the older writes. Two timers also hold issue back. A double-precision operation may issue at most once per seven cycles. A taken branch without a matching hint stops all issue for eighteen cycles. The `adv` output tells the window how many entries were consumed, so it can shift.

Class encoding on `s0_cls`/`s1_cls`: 0 = even-pipe arithmetic (fixed-point, logical, compare, shift, select, byte ops, single-precision multiply-add); 1 = double-precision float (even pipe, rate limited); 2 = odd-pipe permute, local-store load/store or channel access; 3 = branch (odd pipe).

Top module: `pair_issue`

## Requirements
- R1: After reset no timer is pending. The first valid instruction, including a double-precision one, issues in the first cycle it is presented. An empty window gives `adv`=0, no fire and `stall`=0.
- R2: Classes 0 and 1 issue on the even pipe (`ev_fire`). Classes 2 and 3 issue on the odd pipe (`od_fire`).
- R3: When slot 0 and slot 1 are both valid, need different pipes and are independent, both issue in the same cycle (`adv`=2), in either age order. `ev_from1`=1 exactly when the even pipe receives slot 1.
- R4: Two valid instructions needing the same pipe issue one per cycle, oldest first (`adv`=1).
- R5: If slot 0 has `s0_wen`=1 and either source of slot 1 equals `s0_dst`, only slot 0 issues. With `s0_wen`=0 the match has no effect.
- R6: After a double-precision instruction issues in cycle t, no double-precision instruction issues in cycles t+1 to t+6. A blocked double-precision op in slot 0 blocks everything behind it. A blocked one in slot 1 lets slot 0 issue alone.
- R7: A branch that issues with `br_taken`=1 and `br_hint_hit`=0 in cycle t stops all issue in cycles t+1 to t+18. Issue resumes in t+19. This holds whether the branch was in slot 0 or slot 1.
- R8: A taken branch with `br_hint_hit`=1, or a branch with `br_taken`=0, adds no bubble.
- R9: A taken branch in slot 0 issues alone, even when slot 1 could otherwise pair with it.
- R10: Slot 1 never issues unless slot 0 issues in the same cycle. The number of fires always equals `adv`.
- R11: `stall` is high exactly when slot 0 is valid and nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Oldest window entry valid |
| s0_cls | input | 2 | Oldest entry unit class |
| s0_dst | input | REG_W | Oldest entry destination register |
| s0_wen | input | 1 | Oldest entry writes its destination |
| s0_srca | input | REG_W | Oldest entry source A |
| s0_srcb | input | REG_W | Oldest entry source B |
| s1_vld | input | 1 | Younger window entry valid |
| s1_cls | input | 2 | Younger entry unit class |
| s1_dst | input | REG_W | Younger entry destination register |
| s1_wen | input | 1 | Younger entry writes its destination |
| s1_srca | input | REG_W | Younger entry source A |
| s1_srcb | input | REG_W | Younger entry source B |
| br_taken | input | 1 | Branch in the window resolves taken |
| br_hint_hit | input | 1 | A prefetch hint matches the taken target |
| ev_fire | output | 1 | Even pipe receives an instruction |
| od_fire | output | 1 | Odd pipe receives an instruction |
| ev_from1 | output | 1 | Even pipe instruction comes from slot 1 |
| adv | output | 2 | Window entries consumed this cycle |
| stall | output | 1 | Valid oldest entry not issued |

## Verification
The pairing decision is exercised with every ordering of pipe needs. The patterns are even then odd, odd then even, even-even and odd-odd. They separate correct pipe steering and `ev_from1` from a stage that pairs by slot position only. Dependent pairs are tried with the match on either source and with the write flag off, which catches a comparison on the wrong field. The double-precision gap and the branch bubble are probed cycle by cycle up to their edges: the last blocked cycle and the first free one. Hinted, not-taken and slot-1 branches are tried as well.

// File: rtl/pair_pkg.sv
package pair_pkg;
   typedef enum logic [1:0] {
      UC_ALU  = 2'd0,
      UC_DPF  = 2'd1,
      UC_PERM = 2'd2,
      UC_BR   = 2'd3
   } ucls_e;
endpackage

// File: rtl/slot_class.sv
module slot_class
   import pair_pkg::*;
(
   input  logic [1:0] cls,
   output logic       odd_pipe,
   output logic       is_dp,
   output logic       is_br
);
   ucls_e c;
   always_comb begin
      c        = ucls_e'(cls);
      odd_pipe = (c == UC_PERM) || (c == UC_BR);
      is_dp    = (c == UC_DPF);
      is_br    = (c == UC_BR);
   end
endmodule

// File: rtl/raw_check.sv
module raw_check #(
   parameter int REG_W = 7
) (
   input  logic             old_wen,
   input  logic [REG_W-1:0] old_dst,
   input  logic [REG_W-1:0] yng_srca,
   input  logic [REG_W-1:0] yng_srcb,
   output logic             dep
);
   always_comb dep = old_wen && ((yng_srca == old_dst) || (yng_srcb == old_dst));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   generate
      if (LEN < 0) begin : g_bad
         $error("hold_timer: LEN must not be negative");
      end else if (LEN == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_cnt
         localparam int CW = $clog2(LEN + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (load)        cnt <= CW'(LEN);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/pair_issue.sv
module pair_issue #(
   parameter int REG_W  = 7,
   parameter int DP_GAP = 7,
   parameter int BR_PEN = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s0_vld,
   input  logic [1:0]       s0_cls,
   input  logic [REG_W-1:0] s0_dst,
   input  logic             s0_wen,
   input  logic [REG_W-1:0] s0_srca,
   input  logic [REG_W-1:0] s0_srcb,
   input  logic             s1_vld,
   input  logic [1:0]       s1_cls,
   input  logic [REG_W-1:0] s1_dst,
   input  logic             s1_wen,
   input  logic [REG_W-1:0] s1_srca,
   input  logic [REG_W-1:0] s1_srcb,
   input  logic             br_taken,
   input  logic             br_hint_hit,
   output logic             ev_fire,
   output logic             od_fire,
   output logic             ev_from1,
   output logic [1:0]       adv,
   output logic             stall
);
   localparam int NSLOT  = 2;
   localparam int DP_LEN = DP_GAP - 1;

   generate
      if (REG_W < 1)  begin : g_chk_w   $error("pair_issue: REG_W must be >= 1");  end
      if (DP_GAP < 1) begin : g_chk_dp  $error("pair_issue: DP_GAP must be >= 1"); end
      if (BR_PEN < 0) begin : g_chk_br  $error("pair_issue: BR_PEN must be >= 0"); end
   endgenerate

   logic [1:0]       cls_a [NSLOT];
   logic [NSLOT-1:0] odd_p, dp_f, br_f;

   assign cls_a[0] = s0_cls;
   assign cls_a[1] = s1_cls;

   genvar gi;
   generate
      for (gi = 0; gi < NSLOT; gi++) begin : g_slot
         slot_class u_cls (
            .cls      (cls_a[gi]),
            .odd_pipe (odd_p[gi]),
            .is_dp    (dp_f[gi]),
            .is_br    (br_f[gi])
         );
      end
   endgenerate

   logic dep;
   raw_check #(.REG_W(REG_W)) u_raw (
      .old_wen  (s0_wen),
      .old_dst  (s0_dst),
      .yng_srca (s1_srca),
      .yng_srcb (s1_srcb),
      .dep      (dep)
   );

   logic dp_busy, br_busy, dp_iss, br_load;

   hold_timer #(.LEN(DP_LEN)) u_dp_gap (
      .clk (clk), .rst_n (rst_n), .load (dp_iss), .busy (dp_busy)
   );
   hold_timer #(.LEN(BR_PEN)) u_br_gap (
      .clk (clk), .rst_n (rst_n), .load (br_load), .busy (br_busy)
   );

   logic ok0, pair_ok, redirect0, s1_unused;

   always_comb begin
      redirect0 = br_f[0] && br_taken;
      ok0       = s0_vld && !br_busy && (!dp_f[0] || !dp_busy);
      pair_ok   = ok0 && s1_vld && (odd_p[0] != odd_p[1]) && !dep
                  && !redirect0 && (!dp_f[1] || !dp_busy);
      adv       = ok0 ? (pair_ok ? 2'd2 : 2'd1) : 2'd0;
      ev_fire   = ok0 && (!odd_p[0] || pair_ok);
      od_fire   = ok0 && ( odd_p[0] || pair_ok);
      ev_from1  = pair_ok && odd_p[0];
      stall     = s0_vld && !ok0;
      dp_iss    = (ok0 && dp_f[0]) || (pair_ok && dp_f[1]);
      br_load   = ((ok0 && br_f[0]) || (pair_ok && br_f[1])) && br_taken && !br_hint_hit;
      s1_unused = ^{s1_dst, s1_wen};
   end
endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
   parameter int REG_W  = 7,
   parameter int DP_GAP = 7,
   parameter int BR_PEN = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s0_vld,
   input logic [1:0]       s0_cls,
   input logic [REG_W-1:0] s0_dst,
   input logic             s0_wen,
   input logic             s1_vld,
   input logic [1:0]       s1_cls,
   input logic [REG_W-1:0] s1_srca,
   input logic [REG_W-1:0] s1_srcb,
   input logic             br_taken,
   input logic             br_hint_hit,
   input logic             ev_fire,
   input logic             od_fire,
   input logic [1:0]       adv,
   input logic             stall
);
   logic dp_go, br_go;
   int   since_dp, bubble;

   always_comb begin
      dp_go = ((adv != 2'd0) && (s0_cls == 2'd1)) || ((adv == 2'd2) && (s1_cls == 2'd1));
      br_go = (((adv != 2'd0) && (s0_cls == 2'd3)) || ((adv == 2'd2) && (s1_cls == 2'd3)))
              && br_taken && !br_hint_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_dp <= DP_GAP;
         bubble   <= 0;
      end else begin
         since_dp <= dp_go ? 1 : ((since_dp < DP_GAP) ? since_dp + 1 : since_dp);
         bubble   <= br_go ? BR_PEN : ((bubble > 0) ? bubble - 1 : 0);
      end
   end

   AST_FIRE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ev_fire, od_fire}) == int'(adv));                                   // R10
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !s0_vld |-> (adv == 2'd0) && !stall);                                           // R1
   AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (adv == 2'd2) |-> (s0_cls[1] != s1_cls[1]));                                    // R3
   AST_PAIR_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv == 2'd2) |-> !(s0_wen && ((s1_srca == s0_dst) || (s1_srcb == s0_dst))));  // R5
   AST_DP_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      dp_go |-> (since_dp >= DP_GAP));                                                // R6
   AST_BR_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bubble > 0) |-> (adv == 2'd0));                                                // R7
   AST_TAKEN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_vld && s0_cls == 2'd3 && br_taken) |-> (adv != 2'd2));                      // R9
   AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!ev_fire && !od_fire && s0_vld));                                    // R11
   AST_S1_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (adv == 2'd2) |-> s1_vld);                                                      // R10
endmodule

bind pair_issue pair_issue_chk #(.REG_W(REG_W), .DP_GAP(DP_GAP), .BR_PEN(BR_PEN)) u_chk (
   .clk (clk), .rst_n (rst_n), .s0_vld (s0_vld), .s0_cls (s0_cls), .s0_dst (s0_dst),
   .s0_wen (s0_wen), .s1_vld (s1_vld), .s1_cls (s1_cls), .s1_srca (s1_srca),
   .s1_srcb (s1_srcb), .br_taken (br_taken), .br_hint_hit (br_hint_hit),
   .ev_fire (ev_fire), .od_fire (od_fire), .adv (adv), .stall (stall)
);

// File: tb/test_pair_issue.sv
module test_pair_issue;
   localparam int CLK_PER = 10;
   localparam int RW = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic s0_vld, s0_wen, s1_vld, s1_wen, br_taken, br_hint_hit;
   logic [1:0] s0_cls, s1_cls, adv;
   logic [RW-1:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
   logic ev_fire, od_fire, ev_from1, stall;
   int n_run = 0, n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   pair_issue i_pair_issue (.*);

   typedef struct packed {
      logic v0; logic [1:0] c0; logic [6:0] d0; logic w0; logic [6:0] a0; logic [6:0] b0;
      logic v1; logic [1:0] c1; logic [6:0] d1; logic w1; logic [6:0] a1; logic [6:0] b1;
      logic [5:0] exp;   // {ev, od, from1, adv[1:0], stall}
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{0,0,0,0,0,0, 0,0,0,0,0,0, 6'b000000},  // R1 empty window
      '{1,0,5,1,1,2, 0,0,0,0,0,0, 6'b100010},  // R2 lone even
      '{1,2,5,1,1,2, 0,0,0,0,0,0, 6'b010010},  // R2 lone odd
      '{1,0,5,1,1,2, 1,2,6,1,3,4, 6'b110100},  // R3 even then odd
      '{1,2,5,1,1,2, 1,0,6,1,3,4, 6'b111100},  // R3 odd then even
      '{1,0,5,1,1,2, 1,0,6,1,3,4, 6'b100010},  // R4 even-even
      '{1,2,5,1,1,2, 1,3,6,1,3,4, 6'b010010},  // R4 odd-odd
      '{1,0,5,1,1,2, 1,2,6,1,5,4, 6'b100010},  // R5 src A hazard
      '{1,2,5,1,1,2, 1,0,6,1,3,5, 6'b010010},  // R5 src B hazard
      '{1,2,5,0,1,2, 1,0,6,1,5,5, 6'b111100},  // R5 no write, no hazard
      '{1,3,5,0,1,2, 1,0,6,1,3,4, 6'b111100},  // R8 untaken branch pairs
      '{0,0,5,1,1,2, 1,2,6,1,3,4, 6'b000000}   // R10 slot1 alone never goes
   };

   task automatic drive(logic v0, logic [1:0] c0, logic [6:0] d0, logic w0,
                        logic v1, logic [1:0] c1, logic [6:0] a1, logic tk, logic hh);
      s0_vld = v0; s0_cls = c0; s0_dst = d0; s0_wen = w0; s0_srca = 7'd1; s0_srcb = 7'd2;
      s1_vld = v1; s1_cls = c1; s1_dst = 7'd9; s1_wen = 1'b1; s1_srca = a1; s1_srcb = 7'd4;
      br_taken = tk; br_hint_hit = hh;
   endtask

   task automatic chk(string req, logic [5:0] exp);
      logic [5:0] got;
      got = {ev_fire, od_fire, ev_from1, adv, stall};
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
      end
   endtask

   // next negedge, apply, settle, check
   task automatic step(string req, logic [5:0] exp);
      #1 chk(req, exp);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PER * 5000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {s0_vld, s0_cls, s0_dst, s0_wen, s0_srca, s0_srcb,
          s1_vld, s1_cls, s1_dst, s1_wen, s1_srca, s1_srcb} = TBL[i][$bits(vec_t)-1:6];
         br_taken = 0; br_hint_hit = 0;
         step("R2/R3/R4/R5 table", TBL[i].exp);
      end

      // R1/R6: first DP after reset goes at once, then gap of seven
      drive(1, 1, 5, 1, 0, 0, 3, 0, 0); step("R1 first DP", 6'b100010);
      drive(1, 2, 5, 1, 1, 1, 3, 0, 0); step("R6 slot1 DP held", 6'b010010);
      for (int k = 2; k <= 6; k++) begin
         drive(1, 1, 5, 1, 0, 0, 3, 0, 0); step("R6 DP blocked", 6'b000001);
      end
      drive(1, 2, 5, 1, 1, 1, 3, 0, 0); step("R6 DP after gap pairs", 6'b111100);
      drive(1, 0, 5, 1, 0, 0, 3, 0, 0); step("R6 ALU unaffected by gap", 6'b100010);

      // R9/R7: taken unhinted branch in slot0
      drive(1, 3, 5, 0, 1, 0, 3, 1, 0); step("R9 taken branch alone", 6'b010010);
      for (int k = 1; k <= 18; k++) begin
         drive(1, 0, 5, 1, 0, 0, 3, 0, 0); step("R7 bubble", 6'b000001);
      end
      drive(1, 0, 5, 1, 0, 0, 3, 0, 0); step("R7 resume t+19", 6'b100010);

      // R8: hinted taken branch, no bubble
      drive(1, 3, 5, 0, 0, 0, 3, 1, 1); step("R8 hinted branch", 6'b010010);
      drive(1, 0, 5, 1, 0, 0, 3, 0, 0); step("R8 no bubble", 6'b100010);

      // R7: taken branch in slot1
      drive(1, 0, 5, 1, 1, 3, 3, 1, 0); step("R7 slot1 branch pairs", 6'b110100);
      drive(1, 2, 5, 1, 0, 0, 3, 0, 0); step("R7 slot1 branch bubble", 6'b000001);

      // R1: reset clears pending bubble
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      drive(1, 2, 5, 1, 0, 0, 3, 0, 0); step("R1 issue after reset", 6'b010010);
      drive(0, 0, 5, 1, 0, 0, 3, 0, 0); step("R11 idle no stall", 6'b000000);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule